// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Coherent Two-Byte Read

The block keeps a 12-bit count of elapsed microseconds. The count runs from a faster system clock through a divider that issues a one-cycle enable every `DIV` system cycles, which is once per microsecond at the default 6 MHz. The count rolls from 0xFFF back to 0x000 and never stops.

Software reads the count through an 8-bit read port that has two addresses. Address 0 returns the low byte. The same read also copies the top four bits into a holding register. Address 1 returns that holding register rather than the live bits, so a low read followed by a high read always yields one consistent 12-bit value.

Two outputs each give a one-cycle pulse whenever a chosen count bit goes from 0 to 1. The first taps bit 7, which has a weight of 128 µs. The second taps bit 10, which has a weight of 1024 µs. These pulses feed an interrupt controller.

Top module: `fr_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the count, the divider and the holding register are zero, `rd_data` is 0 and both tick outputs are low.
- R2: The count increases by exactly one every `DIV` system cycles (default 6). The first increment happens at the `DIV`-th rising edge after reset is released.
- R3: The count wraps from 0xFFF to 0x000 and keeps counting.
- R4: A read with `rd_en`=1 and `rd_addr`=0 puts count bits [7:0] on `rd_data` one cycle later.
- R5: A read at `rd_addr`=0 copies count bits [11:8] into the holding register.
- R6: A read with `rd_en`=1 and `rd_addr`=1 puts {4'b0000, holding register} on `rd_data` one cycle later. This value does not depend on the live count, and a high read leaves the holding register unchanged.
- R7: `tick_128` is high for exactly one cycle: the cycle in which count bit 7 has just changed from 0 to 1.
- R8: `tick_1024` is high for exactly one cycle: the cycle in which count bit 10 has just changed from 0 to 1.
- R9: A low read in the same cycle as an increment returns the low byte from before the increment, and latches the nibble from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 1 | 0 selects the low byte, 1 selects the held high nibble |
| rd_data | output | 8 | Registered read data |
| tick_128 | output | 1 | Pulse when count bit 7 rises |
| tick_1024 | output | 1 | Pulse when count bit 10 rises |

## Verification
The bench numbers the rising edges since reset release as k. After edge k it expects the count to be floor(k/6) mod 4096. A read presented before edge k is due on `rd_data` in the cycle after that edge, and it carries the count as it stood at edge k-1. The tick outputs are due in the cycle right after the edge that raised the tapped bit. All outputs are sampled on the falling edge. Read gaps vary, so low reads land on every divider phase, including the increment edge, and they also land after the wrap.

// File: rtl/fr_timer_pkg.sv
package fr_timer_pkg;
    localparam int CNT_W = 12;
    localparam int LO_W  = 8;
    localparam int HI_W  = CNT_W - LO_W;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [LO_W-1:0]  byte_t;
    typedef logic [HI_W-1:0]  nib_t;

    typedef enum logic {SEL_LO = 1'b0, SEL_HI = 1'b1} rd_sel_e;

    typedef struct packed {
        logic    en;
        rd_sel_e sel;
    } rd_req_t;

    function automatic cnt_t cnt_step(cnt_t v);
        return v + cnt_t'(1);
    endfunction
endpackage

// File: rtl/fr_prescaler.sv
module fr_prescaler #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic us_en
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == PW'(DIV - 1)) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    assign us_en = (phase == PW'(DIV - 1));

    a_r2_enable_spacing: assert property (@(posedge clk) disable iff (rst)
        us_en |=> !us_en);
endmodule

// File: rtl/fr_counter.sv
module fr_counter
    import fr_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic us_en,
    output cnt_t cnt,
    output cnt_t cnt_nxt
);
    assign cnt_nxt = cnt_step(cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (us_en) begin
            cnt <= cnt_nxt;
        end
    end

    a_r2_step_on_enable: assert property (@(posedge clk) disable iff (rst)
        us_en |=> (cnt == cnt_t'($past(cnt) + 1)));
    a_r2_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
        !us_en |=> $stable(cnt));
endmodule

// File: rtl/fr_edge_tap.sv
module fr_edge_tap (
    input  logic clk,
    input  logic rst,
    input  logic us_en,
    input  logic cur_bit,
    input  logic nxt_bit,
    output logic tick
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= 1'b0;
        end else begin
            tick <= us_en & ~cur_bit & nxt_bit;
        end
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    a_r8_pulse_after_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(tick) |-> $past(us_en));
endmodule

// File: rtl/fr_read_latch.sv
module fr_read_latch
    import fr_timer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rd_req_t req,
    input  cnt_t    cnt,
    output byte_t   rd_data
);
    nib_t hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= '0;
            rd_data <= '0;
        end else if (req.en) begin
            if (req.sel == SEL_LO) begin
                rd_data <= cnt[LO_W-1:0];
                hold    <= cnt[CNT_W-1:LO_W];
            end else begin
                rd_data <= byte_t'(hold);
            end
        end
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        (req.en && req.sel == SEL_LO) |=> (hold == $past(cnt[CNT_W-1:LO_W])));
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !(req.en && req.sel == SEL_LO) |=> $stable(hold));
    a_r6_high_is_hold: assert property (@(posedge clk) disable iff (rst)
        (req.en && req.sel == SEL_HI) |=> (rd_data == byte_t'($past(hold))));
endmodule

// File: rtl/fr_timer.sv
module fr_timer
    import fr_timer_pkg::*;
#(
    parameter int DIV    = 6,
    parameter int TAP_LO = 7,
    parameter int TAP_HI = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    output logic       tick_128,
    output logic       tick_1024
);
    localparam int NTAP = 2;

    logic            us_en;
    cnt_t            cnt;
    cnt_t            cnt_nxt;
    logic [NTAP-1:0] ticks;
    rd_req_t         req;

    assign req.en  = rd_en;
    assign req.sel = rd_sel_e'(rd_addr);

    fr_prescaler #(.DIV(DIV)) i_pre (
        .clk(clk), .rst(rst), .us_en(us_en)
    );

    fr_counter i_cnt (
        .clk(clk), .rst(rst), .us_en(us_en), .cnt(cnt), .cnt_nxt(cnt_nxt)
    );

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        localparam int TB = (g == 0) ? TAP_LO : TAP_HI;
        fr_edge_tap i_tap (
            .clk(clk), .rst(rst), .us_en(us_en),
            .cur_bit(cnt[TB]), .nxt_bit(cnt_nxt[TB]), .tick(ticks[g])
        );
    end

    fr_read_latch i_rd (
        .clk(clk), .rst(rst), .req(req), .cnt(cnt), .rd_data(rd_data)
    );

    assign tick_128  = ticks[0];
    assign tick_1024 = ticks[1];

    a_r7_tap_lo_set: assert property (@(posedge clk) disable iff (rst)
        tick_128 |-> (cnt[TAP_LO] && !$past(cnt[TAP_LO])));
    a_r8_tap_hi_set: assert property (@(posedge clk) disable iff (rst)
        tick_1024 |-> (cnt[TAP_HI] && !$past(cnt[TAP_HI])));
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!tick_128 && !tick_1024 && rd_data == 8'd0));
endmodule

// File: tb/test_fr_timer.sv
module test_fr_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       tick_128, tick_1024;

    int n_checks = 0;
    int n_errors = 0;
    int k = 0;
    bit run_ticks = 1'b0;
    int last_lo_k = 0;

    localparam int DIV = 6;

    always #5 clk = ~clk;

    fr_timer i_fr_timer (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .tick_128(tick_128), .tick_1024(tick_1024)
    );

    always @(posedge clk) k <= rst ? 0 : k + 1;

    function automatic int count_at(int edges);
        return (edges / DIV) % 4096;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
        end
    endtask

    always @(negedge clk) begin
        if (run_ticks) begin
            int c;
            bit due;
            c = count_at(k);
            due = (k > 0) && (k % DIV == 0);
            check("R7 tick_128", int'(tick_128), int'(due && (c % 256 == 128)));
            check("R8 tick_1024", int'(tick_1024), int'(due && (c % 2048 == 1024)));
        end
    end

    task automatic do_read(bit hi, output int edge_k);
        rd_en = 1'b1;
        rd_addr = hi;
        @(posedge clk);
        @(negedge clk);
        edge_k = k;
        rd_en = 1'b0;
    endtask

    task automatic read_lo_check();
        int ek, v;
        do_read(1'b0, ek);
        v = count_at(ek - 1);
        last_lo_k = ek;
        if (ek % DIV == 0)
            check("R9 low byte at increment", int'(rd_data), v % 256);
        else if ((ek - 1) / DIV >= 4096)
            check("R3 low byte after wrap", int'(rd_data), v % 256);
        else
            check("R4 low byte", int'(rd_data), v % 256);
    endtask

    task automatic read_hi_check(string req);
        int ek;
        do_read(1'b1, ek);
        check(req, int'(rd_data), (count_at(last_lo_k - 1) >> 8) & 15);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 rd_data in reset", int'(rd_data), 0);
        check("R1 tick_128 in reset", int'(tick_128), 0);
        check("R1 tick_1024 in reset", int'(tick_1024), 0);
        rst = 1'b0;
        run_ticks = 1'b1;
        begin
            int ek;
            do_read(1'b1, ek);
            check("R1 hold cleared", int'(rd_data), 0);
        end
        read_lo_check();
        check("R2 first low read", int'(rd_data), 0);
        repeat (DIV * 700) @(negedge clk);
        read_lo_check();
        check("R2 count after 700 us", int'(rd_data), count_at(last_lo_k - 1) % 256);
        read_hi_check("R5 nibble latched");
        repeat (DIV * 300) @(negedge clk);
        read_hi_check("R6 high read is held value");
        read_hi_check("R6 high read leaves hold");
        for (int i = 0; k < DIV * 4096 + 900; i++) begin
            read_lo_check();
            read_hi_check("R5 nibble matches low read");
            repeat (i % 7) @(negedge clk);
        end
        run_ticks = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule